// File: doc/BRIEF.md
# Adaptive Probability Bit-Tree Symbol Decoder

This block turns an arithmetic-coded byte stream into multi-bit symbols. It holds the decoder's interval width and code value and a store of 256 adaptive probabilities. For each requested symbol it walks a binary tree one level at a time. At every level it reads the probability selected by the bits decoded so far, decodes one bit against it, and writes the adapted probability back before the next level. When the interval gets too narrow it pulls one more byte from upstream through a request/valid handshake.

A caller pulses `start` with a mode, a level count and a constant to add at the end. Forward mode builds the symbol from the most significant bit down, behind a leading marker bit. The constant can remove that marker and apply an offset. Reverse mode decodes a 4-bit value from the least significant bit up. The block answers with a single-cycle `done` and holds the symbol on `symbol`. After reset or `clear`, the block first loads its code value from five stream bytes.

Top module: `bittree_decoder`

## Requirements
- R1: After reset or `clear`, the block consumes exactly five bytes through the byte handshake before `ready` rises. Each accepted byte is shifted into the low end of the 32-bit code register, so the first byte drops out. The interval width starts at 0xFFFFFFFF.
- R2: In forward mode the working value starts at 1. Level n reads the probability entry whose index equals the working value. It then becomes 2*value + bit. The number of levels is taken from `levels` (1 to 8; 3, 6 and 8 are the intended sizes).
- R3: In forward mode `symbol` equals the final working value, marker included, plus `final_add`, modulo 2^16. For example, 0xFF00 removes the marker of an 8-level tree.
- R4: In reverse mode exactly four bits are decoded and the working value starts at 0. Step k (0..3) reads entry value + 2^k and adds 2^k when the bit is 1. `symbol` is the 4-bit result. `final_add` and `levels` have no effect.
- R5: Bit decode works as follows. bound = (width >> 11) * p. The bit is 0 when code < bound; then width becomes bound and p gains (2048 - p) >> 5. Otherwise width and code both lose bound and p loses p >> 5. The updated entry is stored and used by every later read.
- R6: Before every bit, if the width is below 2^24, `byte_req` rises and decoding waits until `byte_valid`. The byte is then taken once: width shifts left 8 and code shifts in the byte. No byte is requested otherwise.
- R7: With `byte_valid` held high, `done` is high for exactly one cycle, 2 cycles per decoded bit after the start edge. `symbol` changes only at that edge and holds its value until the next result.
- R8: `start` is accepted only while `ready` is high. A start during a decode or during loading has no effect on that decode.
- R9: `clear` resets every probability entry to 1024 and restarts the five-byte load of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Reinitialise probabilities and reload the code value |
| start | input | 1 | Begin one symbol decode (taken only when ready) |
| rev_mode | input | 1 | 1 = 4-bit reverse tree, 0 = forward tree |
| levels | input | 4 | Forward tree depth, 1 to 8 |
| final_add | input | 16 | Constant added to the forward result |
| byte_valid | input | 1 | Upstream byte present on byte_data |
| byte_data | input | 8 | Next stream byte |
| byte_req | output | 1 | Block wants a stream byte this cycle |
| ready | output | 1 | Idle and loaded, start is accepted |
| done | output | 1 | One-cycle result strobe |
| symbol | output | 16 | Last decoded symbol |

## Verification
The bench keeps its own model of the arithmetic decoder and probability store, fed from the same byte stream. Each decoded symbol and the number of bytes taken are compared with it, over long mixed runs in which earlier updates steer later bits. A design that wrote probabilities back late, or to the wrong index, would drift from the model within a few symbols. A design that normalised at the wrong threshold, or twice, would show a wrong byte count. Reverse decodes use a non-zero add constant and an unusual level count, so a design that applied either one would return a wrong value. Starved byte input, a start pulse in mid-decode and a `clear` followed by a reload each target a specific failure: a decode that runs on without its byte, a restart or mode switch part-way, and probabilities or code value left stale.

// File: rtl/bt_dec_pkg.sv
// Package: shared constants and the sequencing state type of the bit-tree
// decoder. Assumes an 11-bit probability model held in 16-bit entries.
package bt_dec_pkg;
    localparam int PROB_BITS  = 11;
    localparam int MOVE_BITS  = 5;
    localparam int PROB_W     = 16;
    localparam int MAX_LEVELS = 8;
    localparam int REV_LEVELS = 4;
    localparam int SYM_W      = 16;
    localparam int CODE_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int INIT_BYTES = 5;
    localparam int LVL_W      = $clog2(MAX_LEVELS + 1);

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_NORM,
        ST_DEC,
        ST_DONE
    } dec_state_t;
endpackage

// File: rtl/bt_prob_store.sv
// Probability store: one register per entry, combinational read and one
// write port. Reset or clear sets every entry to INIT_VAL in one cycle.
// Assumes the reader uses the read data in the same cycle as the write.
module bt_prob_store #(
    parameter int IDX_W    = 8,
    parameter int PROB_W   = 16,
    parameter int INIT_VAL = 1024,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PROB_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PROB_W-1:0] wr_data
);
    logic [PROB_W-1:0] entry_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        // Hold one probability; reload on clear, replace on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                entry_q[gi] <= PROB_W'(INIT_VAL);
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                entry_q[gi] <= wr_data;
            end
        end
    end

    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/bt_bit_engine.sv
// Bit engine: decodes one bit from the interval width, code value and
// probability, and gives the narrowed interval and adapted probability.
// Purely combinational; assumes the width was normalised beforehand.
module bt_bit_engine #(
    parameter int CODE_W    = 32,
    parameter int PROB_W    = 16,
    parameter int PROB_BITS = 11,
    parameter int MOVE_BITS = 5
) (
    input  logic [CODE_W-1:0] range_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PROB_W-1:0] prob_i,
    output logic              bit_o,
    output logic [CODE_W-1:0] range_o,
    output logic [CODE_W-1:0] code_o,
    output logic [PROB_W-1:0] prob_o
);
    localparam int PROB_TOTAL = 1 << PROB_BITS;

    logic [CODE_W-1:0] bound;

    // Split the interval at the probability point and adapt the entry.
    always_comb begin
        bound = (range_i >> PROB_BITS) * CODE_W'(prob_i);
        if (code_i < bound) begin
            bit_o   = 1'b0;
            range_o = bound;
            code_o  = code_i;
            prob_o  = prob_i + ((PROB_W'(PROB_TOTAL) - prob_i) >> MOVE_BITS);
        end else begin
            bit_o   = 1'b1;
            range_o = range_i - bound;
            code_o  = code_i - bound;
            prob_o  = prob_i - (prob_i >> MOVE_BITS);
        end
    end
endmodule

// File: rtl/bt_tree_walk.sv
// Tree walker: keeps the partly decoded value and level count, forms the
// probability index for the current level and the finished symbol.
// Forward trees grow MSB-first behind a marker bit; the reverse tree grows
// LSB-first with power-of-two index offsets. Parameters latch on load.
module bt_tree_walk #(
    parameter int IDX_W      = 8,
    parameter int LVL_W      = 4,
    parameter int REV_LEVELS = 4,
    parameter int SYM_W      = 16,
    localparam int SW        = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rev_i,
    input  logic [LVL_W-1:0]  levels_i,
    input  logic [SYM_W-1:0]  final_add_i,
    input  logic              step,
    input  logic              bit_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              last_o,
    output logic [SYM_W-1:0]  result_o
);
    logic [SW-1:0]    sym_q;
    logic [SW-1:0]    sym_next;
    logic [SW-1:0]    weight;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] levels_q;
    logic [SYM_W-1:0] fadd_q;
    logic             rev_q;

    // Index, next value and finished symbol for the current level.
    always_comb begin
        weight = SW'(1) << lvl_q;
        if (rev_q) begin
            idx_o    = IDX_W'(sym_q + weight);
            sym_next = sym_q | (bit_i ? weight : '0);
            last_o   = (lvl_q == LVL_W'(REV_LEVELS - 1));
            result_o = SYM_W'(sym_next);
        end else begin
            idx_o    = sym_q[IDX_W-1:0];
            sym_next = {sym_q[IDX_W-1:0], bit_i};
            last_o   = (lvl_q == levels_q - LVL_W'(1));
            result_o = SYM_W'(sym_next) + fadd_q;
        end
    end

    // Latch the request on load and advance one level per decoded bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q    <= '0;
            lvl_q    <= '0;
            levels_q <= '0;
            fadd_q   <= '0;
            rev_q    <= 1'b0;
        end else if (load) begin
            sym_q    <= rev_i ? '0 : SW'(1);
            lvl_q    <= '0;
            levels_q <= levels_i;
            fadd_q   <= final_add_i;
            rev_q    <= rev_i;
        end else if (step) begin
            sym_q <= sym_next;
            lvl_q <= lvl_q + LVL_W'(1);
        end
    end
endmodule

// File: rtl/bittree_decoder.sv
// Top level: sequences the code-value load, per-level normalisation and
// bit decode, and returns one symbol per start. Each level takes a
// normalise cycle then a decode cycle whose probability write lands before
// the next level's read. Assumes byte_data is stable while byte_valid.
module bittree_decoder
    import bt_dec_pkg::*;
#(
    parameter int P_PROB_BITS  = PROB_BITS,
    parameter int P_MOVE_BITS  = MOVE_BITS,
    parameter int P_PROB_W     = PROB_W,
    parameter int P_MAX_LEVELS = MAX_LEVELS,
    parameter int P_REV_LEVELS = REV_LEVELS,
    parameter int P_SYM_W      = SYM_W,
    parameter int P_CODE_W     = CODE_W,
    parameter int P_BYTE_W     = BYTE_W,
    parameter int P_INIT_BYTES = INIT_BYTES,
    parameter int P_LVL_W      = LVL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                start,
    input  logic                rev_mode,
    input  logic [P_LVL_W-1:0]  levels,
    input  logic [P_SYM_W-1:0]  final_add,
    input  logic                byte_valid,
    input  logic [P_BYTE_W-1:0] byte_data,
    output logic                byte_req,
    output logic                ready,
    output logic                done,
    output logic [P_SYM_W-1:0]  symbol
);
    localparam int IDX_W    = P_MAX_LEVELS;
    localparam int CNT_W    = $clog2(P_INIT_BYTES + 1);
    localparam int INIT_VAL = 1 << (P_PROB_BITS - 1);

    dec_state_t          state_q;
    logic [P_CODE_W-1:0] range_q;
    logic [P_CODE_W-1:0] code_q;
    logic [CNT_W-1:0]    load_left_q;
    logic [P_SYM_W-1:0]  symbol_q;

    logic                need_byte;
    logic [P_CODE_W-1:0] code_shifted;
    logic                walk_load;
    logic                walk_step;
    logic [IDX_W-1:0]    walk_idx;
    logic                walk_last;
    logic [P_SYM_W-1:0]  walk_result;
    logic [P_PROB_W-1:0] prob_cur;
    logic [P_PROB_W-1:0] prob_new;
    logic                store_we;
    logic                eng_bit;
    logic [P_CODE_W-1:0] eng_range;
    logic [P_CODE_W-1:0] eng_code;

    // Handshake and control decodes derived from the sequencing state.
    always_comb begin
        need_byte    = (range_q[P_CODE_W-1 -: P_BYTE_W] == '0);
        code_shifted = {code_q[P_CODE_W-P_BYTE_W-1:0], byte_data};
        byte_req     = (state_q == ST_LOAD) || ((state_q == ST_NORM) && need_byte);
        ready        = (state_q == ST_IDLE);
        done         = (state_q == ST_DONE);
        walk_load    = (state_q == ST_IDLE) && start;
        walk_step    = (state_q == ST_DEC);
        store_we     = (state_q == ST_DEC);
    end

    bt_prob_store #(
        .IDX_W    (IDX_W),
        .PROB_W   (P_PROB_W),
        .INIT_VAL (INIT_VAL)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .rd_idx  (walk_idx),
        .rd_data (prob_cur),
        .wr_en   (store_we),
        .wr_idx  (walk_idx),
        .wr_data (prob_new)
    );

    bt_bit_engine #(
        .CODE_W    (P_CODE_W),
        .PROB_W    (P_PROB_W),
        .PROB_BITS (P_PROB_BITS),
        .MOVE_BITS (P_MOVE_BITS)
    ) u_engine (
        .range_i (range_q),
        .code_i  (code_q),
        .prob_i  (prob_cur),
        .bit_o   (eng_bit),
        .range_o (eng_range),
        .code_o  (eng_code),
        .prob_o  (prob_new)
    );

    bt_tree_walk #(
        .IDX_W      (IDX_W),
        .LVL_W      (P_LVL_W),
        .REV_LEVELS (P_REV_LEVELS),
        .SYM_W      (P_SYM_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (walk_load),
        .rev_i       (rev_mode),
        .levels_i    (levels),
        .final_add_i (final_add),
        .step        (walk_step),
        .bit_i       (eng_bit),
        .idx_o       (walk_idx),
        .last_o      (walk_last),
        .result_o    (walk_result)
    );

    // Sequencing state, interval width and code value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q     <= ST_LOAD;
            range_q     <= '1;
            code_q      <= '0;
            load_left_q <= CNT_W'(P_INIT_BYTES);
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (byte_valid) begin
                        code_q      <= code_shifted;
                        load_left_q <= load_left_q - CNT_W'(1);
                        if (load_left_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (!need_byte) begin
                        state_q <= ST_DEC;
                    end else if (byte_valid) begin
                        range_q <= range_q << P_BYTE_W;
                        code_q  <= code_shifted;
                        state_q <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    range_q <= eng_range;
                    code_q  <= eng_code;
                    state_q <= walk_last ? ST_DONE : ST_NORM;
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_LOAD;
                end
            endcase
        end
    end

    // Result register, written only when the last level is decoded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            symbol_q <= '0;
        end else if ((state_q == ST_DEC) && walk_last) begin
            symbol_q <= walk_result;
        end
    end

    assign symbol = symbol_q;
endmodule

// File: rtl/bittree_decoder_chk.sv
// Checker: temporal properties of the decoder ports and of its probability
// write-back. Attached to every instance of the top by the bind below.
module bittree_decoder_chk #(
    parameter int SYM_W      = 16,
    parameter int PROB_W     = 16,
    parameter int PROB_TOTAL = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              done,
    input logic              byte_req,
    input logic [SYM_W-1:0]  symbol,
    input logic              st_we,
    input logic [PROB_W-1:0] st_wdata
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_SYMBOL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(symbol) |-> done); // R7

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !byte_req); // R6

    AST_REQ_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> !ready); // R6

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> (!ready && !done)); // R8

    AST_PROB_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> ((st_wdata != '0) && (st_wdata < PROB_W'(PROB_TOTAL)))); // R5
endmodule

bind bittree_decoder bittree_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (ready),
    .done     (done),
    .byte_req (byte_req),
    .symbol   (symbol),
    .st_we    (store_we),
    .st_wdata (prob_new)
);

// File: tb/bittree_decoder_bench.sv
// Directed bench: a behavioural model of the decoder runs on the same byte
// stream, and each scenario task compares symbols, byte counts and timing.
module bittree_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        start = 1'b0;
    logic        rev_mode = 1'b0;
    logic [3:0]  levels = 4'd0;
    logic [15:0] final_add = 16'd0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data;
    logic        byte_req;
    logic        ready;
    logic        done;
    logic [15:0] symbol;

    logic [7:0]  stream [0:4095];
    int          ptr = 0;
    int          checks = 0;
    int          fails = 0;
    int          wd = 0;

    logic [31:0] m_range;
    logic [31:0] m_code;
    logic [15:0] m_prob [0:255];
    int          m_ptr = 0;

    always #10 clk = ~clk;

    assign byte_data = stream[ptr];

    bittree_decoder u_bittree_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .start      (start),
        .rev_mode   (rev_mode),
        .levels     (levels),
        .final_add  (final_add),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_req   (byte_req),
        .ready      (ready),
        .done       (done),
        .symbol     (symbol)
    );

    // Upstream byte source: advance when the block takes a byte.
    always @(posedge clk) begin
        if (byte_req && byte_valid) ptr <= ptr + 1;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic m_load();
        m_range = 32'hFFFF_FFFF;
        m_code = 32'd0;
        for (int i = 0; i < 5; i++) begin
            m_code = {m_code[23:0], stream[m_ptr]};
            m_ptr = m_ptr + 1;
        end
    endtask

    task automatic m_bit(input int idx, output bit b);
        logic [31:0] bound;
        if (m_range < 32'h0100_0000) begin
            m_range = m_range << 8;
            m_code = {m_code[23:0], stream[m_ptr]};
            m_ptr = m_ptr + 1;
        end
        bound = (m_range >> 11) * {16'd0, m_prob[idx]};
        if (m_code < bound) begin
            m_range = bound;
            m_prob[idx] = m_prob[idx] + ((16'd2048 - m_prob[idx]) >> 5);
            b = 1'b0;
        end else begin
            m_range = m_range - bound;
            m_code = m_code - bound;
            m_prob[idx] = m_prob[idx] - (m_prob[idx] >> 5);
            b = 1'b1;
        end
    endtask

    task automatic m_decode(input bit rev, input int lv, input logic [15:0] fa,
                            output logic [15:0] res);
        int s;
        bit b;
        if (rev) begin
            s = 0;
            for (int k = 0; k < 4; k++) begin
                m_bit(s + (1 << k), b);
                if (b) s = s + (1 << k);
            end
            res = 16'(s);
        end else begin
            s = 1;
            for (int l = 0; l < lv; l++) begin
                m_bit(s, b);
                s = 2 * s + int'(b);
            end
            res = 16'(s) + fa;
        end
    endtask

    // One decode: compare symbol, byte count, latency and hold behaviour.
    task automatic run_decode(input bit rev, input int lv, input logic [15:0] fa,
                              input bit stall, input bit poke, input string req,
                              output logic [15:0] got);
        logic [15:0] exp;
        int cyc;
        m_decode(rev, lv, fa, exp);
        @(negedge clk);
        start = 1'b1; rev_mode = rev; levels = 4'(lv); final_add = fa;
        byte_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (cyc < 2000) begin
            @(posedge clk);
            cyc = cyc + 1;
            @(negedge clk);
            if (done) break;
            if (stall) byte_valid = (cyc % 3 == 0);
            if (poke && cyc == 2) begin
                start = 1'b1; rev_mode = ~rev; levels = 4'd3; final_add = 16'h1234;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        byte_valid = 1'b1;
        got = symbol;
        chk(done === 1'b1, req, "done strobe seen", longint'(done), 1);
        chk(symbol === exp, req, "symbol", longint'(symbol), longint'(exp));
        chk(ptr == m_ptr, "R6", "bytes consumed", ptr, m_ptr);
        if (!stall) chk(cyc == (rev ? 8 : 2 * lv), "R7", "latency", cyc, rev ? 8 : 2 * lv);
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R7", "done one cycle", longint'(done), 0);
        chk(symbol === exp, "R7", "symbol held", longint'(symbol), longint'(exp));
        chk(ready === 1'b1, "R8", "ready after done", longint'(ready), 1);
    endtask

    task automatic test_reset();
        // R1: after reset the block asks for load bytes and is not ready
        chk(byte_req === 1'b1, "R1", "byte_req after reset", longint'(byte_req), 1);
        chk(ready === 1'b0, "R1", "ready after reset", longint'(ready), 0);
        chk(done === 1'b0, "R7", "done after reset", longint'(done), 0);
        chk(symbol === 16'd0, "R7", "symbol after reset", longint'(symbol), 0);
    endtask

    task automatic wait_loaded(input int base, input string req);
        int n;
        n = 0;
        byte_valid = 1'b1;
        while (!ready && n < 50) begin
            @(posedge clk);
            @(negedge clk);
            n = n + 1;
        end
        chk(ready === 1'b1, req, "ready after load", longint'(ready), 1);
        chk(ptr == base + 5, req, "load byte count", ptr, base + 5);
    endtask

    task automatic test_load();
        // R1: five bytes taken, then ready
        wait_loaded(0, "R1");
        m_load();
    endtask

    task automatic test_forward_sizes();
        logic [15:0] got;
        run_decode(1'b0, 8, 16'hFF00, 1'b0, 1'b0, "R2", got);   // R3 marker removed
        chk(got < 16'd256, "R3", "8-level marker removed", longint'(got), 255);
        run_decode(1'b0, 3, 16'hFFFA, 1'b0, 1'b0, "R3", got);   // -8 + 2 offset
        chk(got < 16'd10, "R3", "3-level offset range", longint'(got), 9);
        run_decode(1'b0, 6, 16'h0000, 1'b0, 1'b0, "R2", got);
        chk(got >= 16'd64 && got < 16'd128, "R2", "6-level marker kept", longint'(got), 64);
    endtask

    task automatic test_reverse();
        logic [15:0] got;
        // R4: final_add and levels must not change the 4-bit result
        run_decode(1'b1, 7, 16'h5555, 1'b0, 1'b0, "R4", got);
        chk(got < 16'd16, "R4", "reverse value width", longint'(got), 15);
        run_decode(1'b1, 2, 16'hFFFF, 1'b0, 1'b0, "R4", got);
    endtask

    task automatic test_adapt();
        logic [15:0] got;
        // R5: repeated use of one tree; each result depends on prior updates
        for (int i = 0; i < 24; i++) begin
            run_decode(1'b0, 8, 16'hFF00, 1'b0, 1'b0, "R5", got);
            if (i % 4 == 3) run_decode(1'b1, 4, 16'h0000, 1'b0, 1'b0, "R5", got);
        end
    endtask

    task automatic test_stall();
        logic [15:0] got;
        // R6: starved byte input must hold the decode, not corrupt it
        for (int i = 0; i < 6; i++) begin
            run_decode(1'b0, 8, 16'hFF00, 1'b1, 1'b0, "R6", got);
        end
    endtask

    task automatic test_busy_start();
        logic [15:0] got;
        // R8: a start pulse mid-decode is ignored
        run_decode(1'b0, 8, 16'hFF00, 1'b0, 1'b1, "R8", got);
        run_decode(1'b1, 4, 16'h0000, 1'b0, 1'b1, "R8", got);
    endtask

    task automatic test_clear();
        logic [15:0] got;
        int base;
        // R9: clear resets probabilities and reloads the code value
        @(negedge clk);
        byte_valid = 1'b0;
        clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        base = ptr;
        chk(ready === 1'b0, "R9", "ready after clear", longint'(ready), 0);
        chk(byte_req === 1'b1, "R9", "byte_req after clear", longint'(byte_req), 1);
        wait_loaded(base, "R9");
        for (int i = 0; i < 256; i++) m_prob[i] = 16'd1024;
        m_load();
        run_decode(1'b0, 8, 16'hFF00, 1'b0, 1'b0, "R9", got);
        run_decode(1'b1, 4, 16'h0000, 1'b0, 1'b0, "R9", got);
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'h0123_4567;
        for (int i = 0; i < 4096; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            stream[i] = seed[23:16];
        end
        stream[0] = 8'h00;
        for (int i = 0; i < 256; i++) m_prob[i] = 16'd1024;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_load();
        test_forward_sizes();
        test_reverse();
        test_adapt();
        test_stall();
        test_busy_start();
        test_clear();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule